// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block divides a fast input clock by an integer ratio between 8 and 511. The ratio arrives as a 9-bit unsigned word on a parallel control bus. The block produces one output pulse train whose period is that many input cycles. The ratio is re-read once in every output period, at a fixed point four input cycles before the period ends. The value read there sets the length of the next period. A controller clocked by the divider output can therefore step the ratio from one period to the next, for example to build a fractional-N sequence.

The output high time is not a plain half period. It follows a fixed pattern that depends on the ratio. For ratios of 16 and above, it is half of the octave base of the ratio. For ratios 8 to 15, it is four cycles plus the two low ratio bits. A one-cycle strobe marks the start of every output period, so a downstream checker or controller can tell where each period begins.

Top module: `prog_int_divider`

## Requirements
- R1: The distance between two consecutive rising edges of `div_o` equals, in input clock cycles, the ratio that was latched for that period.
- R2: Every ratio from 8 through 511 is honoured without gaps, including both extremes 8 and 511 and the octave boundaries 255/256.
- R3: A control value below 8 (including 0, the undriven default) is treated as ratio 8 when latched.
- R4: `ratio_i` is latched once per output period, in the cycle where the internal count equals ratio minus 4. A value presented just after a period's rising edge governs the following period, not the current one.
- R5: For a ratio N of 16 or more, `div_o` stays high for P/2 cycles, where P is the largest power of two not above N (8, 16, 32, 64 or 128 cycles).
- R6: For a ratio N from 8 to 15, `div_o` stays high for 4 + (N mod 4) cycles.
- R7: While `rst` is high, `div_o` and `edge_o` are low and the ratio resets to 8. The first rising edge appears in the first cycle after reset is released, and the first period lasts 8 cycles.
- R8: `edge_o` is high for exactly one cycle per period, and only in the first high cycle of `div_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_i | input | 9 | Requested division ratio, unsigned, bit 8 most significant |
| div_o | output | 1 | Divided output pulse train |
| edge_o | output | 1 | One-cycle strobe at each rising edge of `div_o` |

## Verification
The bench aims at the octave boundaries (15/16, 255/256, 511), where a wrong high-time rule would stretch or shorten the pulse by a factor of two. It also aims at the short ratios 8 to 15, where the pulse width wraps from 7 back to 4. Values below 8 are applied to show that a design that failed to clamp them would produce periods shorter than 8 or would stall. The ratio is changed right at each rising edge. A design that sampled it at the wrong time would apply the new ratio one period early, and the length check catches that.

// File: rtl/prog_int_divider.sv
module prog_int_divider #(
  parameter int W     = 9,
  parameter int MIN_N = 8,
  parameter int LEAD  = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ratio_i,
  output logic         div_o,
  output logic         edge_o
);
  localparam logic [W-1:0] NMIN = W'(MIN_N);

  logic [W-1:0] cnt, cur_n, nxt_n, req_n, hi_len;
  logic         at_last, at_samp;

  assign req_n   = (ratio_i < NMIN) ? NMIN : ratio_i;
  assign at_last = (cnt == cur_n - W'(1));
  assign at_samp = (cnt == cur_n - W'(LEAD));

  always_comb begin
    hi_len = W'(4) + W'(cur_n[1:0]);
    for (int b = 4; b < W; b++)
      if (cur_n[b]) hi_len = W'(1) << (b - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cur_n  <= NMIN;
      nxt_n  <= NMIN;
      div_o  <= 1'b0;
      edge_o <= 1'b0;
    end else begin
      cnt    <= at_last ? '0 : cnt + W'(1);
      if (at_samp) nxt_n <= req_n;
      if (at_last) cur_n <= nxt_n;
      div_o  <= (cnt < hi_len);
      edge_o <= (cnt == '0);
    end
  end
endmodule

// File: rtl/prog_int_divider_chk.sv
module prog_int_divider_chk (
  input logic clk,
  input logic rst,
  input logic div_o,
  input logic edge_o
);
  logic [9:0] gap;
  logic [8:0] hi;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      hi   <= '0;
      seen <= 1'b0;
    end else begin
      if (edge_o) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != 10'h3ff) begin
        gap <= gap + 10'd1;
      end
      hi <= div_o ? hi + 9'd1 : 9'd0;
    end
  end

  p_reset_quiet_r7: assert property (@(posedge clk) rst |=> (!div_o && !edge_o));
  p_rise_has_edge_r8: assert property (@(posedge clk) disable iff (rst) $rose(div_o) |-> edge_o);
  p_edge_in_high_r8: assert property (@(posedge clk) disable iff (rst) edge_o |-> div_o);
  p_edge_single_r8: assert property (@(posedge clk) disable iff (rst) edge_o |=> !edge_o);
  p_min_period_r3: assert property (@(posedge clk) disable iff (rst) (edge_o && seen) |-> (gap >= 10'd7));
  p_high_bound_r5: assert property (@(posedge clk) disable iff (rst) div_o |-> (hi < 9'd128));
endmodule

bind prog_int_divider prog_int_divider_chk i_chk (.*);

// File: tb/test_prog_int_divider.sv
module test_prog_int_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] ratio_i = '0;
  logic       div_o, edge_o;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  prog_int_divider i_prog_int_divider (.clk(clk), .rst(rst), .ratio_i(ratio_i),
                                       .div_o(div_o), .edge_o(edge_o));

  function automatic int clamp_ref(int v);
    return (v < 8) ? 8 : v;
  endfunction

  function automatic int pw_ref(int n);
    int p;
    if (n < 16) return 4 + n % 4;
    p = 16;
    while (p * 2 <= n) p = p * 2;
    return p / 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(int k);
    int dir[20] = '{0, 5, 7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 31, 32, 255, 256, 511, 8, 127, 128};
    if (k < 20) return dir[k];
    return int'($urandom % 512);
  endfunction

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cur_exp, nxt_exp, src_val, len, hi, v;
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    check(!div_o && !edge_o, "R7 reset outputs", {div_o, edge_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(edge_o == 1'b1, "R7 first edge after release", edge_o, 1);
    cur_exp = 8;
    src_val = 0;
    v = pick(0);
    ratio_i = 9'(v);
    nxt_exp = clamp_ref(v);
    for (int k = 1; k < 100; k++) begin
      int pend_src;
      pend_src = v;
      len = 1;
      hi = div_o ? 1 : 0;
      @(negedge clk);
      while (!edge_o && len < 1000) begin
        len++;
        hi += div_o ? 1 : 0;
        @(negedge clk);
      end
      if (src_val < 8)
        check(len == cur_exp, "R3 clamped period", len, cur_exp);
      else if (src_val == 511 || src_val == 256 || src_val == 255)
        check(len == cur_exp, "R2 extreme period", len, cur_exp);
      else
        check(len == cur_exp, "R1 R4 period length", len, cur_exp);
      if (cur_exp < 16)
        check(hi == pw_ref(cur_exp), "R6 short high time", hi, pw_ref(cur_exp));
      else
        check(hi == pw_ref(cur_exp), "R5 octave high time", hi, pw_ref(cur_exp));
      check(edge_o && div_o, "R8 strobe at rise", {edge_o, div_o}, 3);
      cur_exp = nxt_exp;
      src_val = pend_src;
      v = pick(k);
      ratio_i = 9'(v);
      nxt_exp = clamp_ref(v);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule